// File: doc/BRIEF.md
# Masked Bit-Operation Register

This block is a register of configurable width whose contents change only on a rising clock edge with the update enable high. A two-bit operation code decides how the incoming data word acts on the stored value.

In load mode the word replaces the stored value. In the other three modes the word is a per-bit mask: each mask bit that is 1 selects one register bit to set, clear or invert, and bits with a 0 mask bit are left as they were.

A surrounding I/O wrapper typically places several of these side by side, one per byte lane, and handles any address decoding there. The block has no back-pressure. Every enabled edge is accepted at once, so the enable acts as a valid that is always ready.

Top module: `bitop_reg`

## Requirements
- R1: While the active-high asynchronous reset `rst` is high, `q` is all zeros, whatever `en`, `op` and `mask` are. The reset takes effect without waiting for a clock edge.
- R2: On a rising edge with `en` low, `q` keeps its previous value.
- R3: On a rising edge with `en` high and `op` = 2'b00, `q` takes the value of `mask` unchanged.
- R4: On a rising edge with `en` high and `op` = 2'b01, `q` becomes `q | mask`.
- R5: On a rising edge with `en` high and `op` = 2'b10, `q` becomes `q & ~mask`.
- R6: On a rising edge with `en` high and `op` = 2'b11, `q` becomes `q ^ mask`.
- R7: With `mask` all zeros, ops 2'b01, 2'b10 and 2'b11 leave `q` unchanged, and op 2'b00 makes `q` zero.
- R8: `q` comes straight from flops. Changing `en`, `op` or `mask` between clock edges does not change `q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous reset, active high |
| en | input | 1 | Update enable for the next rising edge |
| op | input | 2 | Operation: 00 load, 01 set, 10 clear, 11 invert |
| mask | input | WIDTH | Load value or per-bit selection mask |
| q | output | WIDTH | Registered value |

## Verification
An enabled operation shows on `q` after exactly one rising edge. A reset shows at once, with no edge needed. The bench changes its inputs on the falling edge and updates its reference model at the same moment. It compares `q` against that model on the following falling edge, which is half a period after the edge that should have updated it. For R1 and R8 the bench also samples between edges: shortly after an asynchronous reset, and shortly after a change to the inputs in the middle of a cycle.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_SET   = 2'b01,
    OP_CLEAR = 2'b10,
    OP_FLIP  = 2'b11
  } bitop_e;
endpackage

// File: rtl/bitop_lane.sv
// Next-value logic: one slice per bit, chosen by the operation code.
module bitop_lane
  import bitop_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  bitop_e             op,
  input  logic [WIDTH-1:0]   cur,
  input  logic [WIDTH-1:0]   mask,
  output logic [WIDTH-1:0]   nxt
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_comb begin
      unique case (op)
        OP_LOAD:  nxt[b] = mask[b];
        OP_SET:   nxt[b] = cur[b] | mask[b];
        OP_CLEAR: nxt[b] = cur[b] & ~mask[b];
        OP_FLIP:  nxt[b] = cur[b] ^ mask[b];
        default:  nxt[b] = cur[b];
      endcase
    end
  end
endmodule

// File: rtl/bitop_hold.sv
// Enabled storage flops with asynchronous clear.
module bitop_hold #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/bitop_reg.sv
module bitop_reg
  import bitop_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       op,
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] q
);
  bitop_e           op_e;
  logic [WIDTH-1:0] nxt;

  assign op_e = bitop_e'(op);

  bitop_lane #(.WIDTH(WIDTH)) u_lane (
    .op(op_e), .cur(q), .mask(mask), .nxt(nxt)
  );

  bitop_hold #(.WIDTH(WIDTH)) u_hold (
    .clk(clk), .rst(rst), .en(en), .d(nxt), .q(q)
  );

  // Set once an edge has passed out of reset, so $past refers to a live cycle.
  logic live;
  always_ff @(posedge clk or posedge rst) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |-> q == '0);

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
    live && !$past(en) |-> q == $past(q));

  p_load_r3: assert property (@(posedge clk) disable iff (rst)
    live && $past(en) && $past(op) == 2'b00 |-> q == $past(mask));

  p_set_r4: assert property (@(posedge clk) disable iff (rst)
    live && $past(en) && $past(op) == 2'b01 |-> q == ($past(q) | $past(mask)));

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    live && $past(en) && $past(op) == 2'b10 |-> q == ($past(q) & ~$past(mask)));

  p_flip_r6: assert property (@(posedge clk) disable iff (rst)
    live && $past(en) && $past(op) == 2'b11 |-> q == ($past(q) ^ $past(mask)));

  p_zero_mask_r7: assert property (@(posedge clk) disable iff (rst)
    live && $past(en) && $past(mask) == '0 && $past(op) != 2'b00 |-> $stable(q));
endmodule

// File: tb/sim_bitop_reg.sv
module sim_bitop_reg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en  = 1'b0;
  logic [1:0]   op  = 2'b00;
  logic [W-1:0] mask = '0;
  logic [W-1:0] q;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] model = '0;

  bitop_reg #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .en(en), .op(op), .mask(mask), .q(q)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] exp);
    checks++;
    if (q !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, q, exp);
    end
  endtask

  function automatic string tag(input logic e, input logic [1:0] o);
    if (!e) return "R2";
    case (o)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // Drive at a falling edge; the model follows what the next rising edge should do.
  task automatic apply(input logic e, input logic [1:0] o, input logic [W-1:0] m);
    en = e; op = o; mask = m;
    if (e) begin
      case (o)
        2'b00:   model = m;
        2'b01:   model = model | m;
        2'b10:   model = model & ~m;
        default: model = model ^ m;
      endcase
    end
  endtask

  task automatic step(input string req);
    @(negedge clk);
    check(req, model);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state with enable and load driven high
    en = 1'b1; op = 2'b00; mask = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1", '0);
    rst = 1'b0; model = '0;
    apply(1'b0, 2'b00, '0);
    step("R2");

    // Directed operations
    apply(1'b1, 2'b00, 8'hA5); step("R3");
    apply(1'b1, 2'b01, 8'h0F); step("R4");
    apply(1'b1, 2'b10, 8'h81); step("R5");
    apply(1'b1, 2'b11, 8'hFF); step("R6");
    apply(1'b0, 2'b00, 8'h00); step("R2");

    // R7: zero mask
    apply(1'b1, 2'b01, '0); step("R7");
    apply(1'b1, 2'b10, '0); step("R7");
    apply(1'b1, 2'b11, '0); step("R7");
    apply(1'b1, 2'b00, '0); step("R7");
    check("R7", '0);

    // R8: mid-cycle input changes do not reach q
    apply(1'b1, 2'b00, 8'h3C); step("R3");
    #2 en = 1'b1; op = 2'b11; mask = 8'hFF;
    #1 check("R8", model);
    op = 2'b00; mask = 8'h00;
    #1 check("R8", model);

    // Random mix, enable low about a quarter of the time
    for (int i = 0; i < 400; i++) begin
      logic e;
      logic [1:0] o;
      e = ($urandom_range(3) != 0);
      o = 2'($urandom_range(3));
      apply(e, o, W'($urandom));
      step(tag(e, o));
    end

    // R1: asynchronous reset between edges
    apply(1'b1, 2'b00, 8'h77); step("R3");
    #2 rst = 1'b1;
    #1 check("R1", '0);
    @(negedge clk);
    check("R1", '0);
    rst = 1'b0; model = '0;
    apply(1'b1, 2'b01, 8'h12); step("R4");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule